// File: doc/BRIEF.md
# Vector Step Instruction Executor

This block executes a single vector-state stepping and query instruction. Each issued instruction carries a 7-bit selector, a step-enable flag and a record flag. The selector picks one of four actions. It can return the current offset of one of four remap shapes. It can return one of the element counters: source step, destination step, source sub-step or destination sub-step. It can program the pack and unpack mode flags. It can ask an external stepping iterator to advance the source and destination counters. The remap offsets and the counters arrive as inputs. The pack and unpack flags are the only state that this block keeps.

The control is a two-state machine. `ST_IDLE` waits for work. The transition *accept* (issue high) moves it to `ST_RETIRE` and loads the result registers. In `ST_RETIRE`, `res_valid` is high for the retiring instruction. The transition *chain* (issue high again) stays in `ST_RETIRE`. The transition *drain* (issue low) returns to `ST_IDLE`. When the record flag is set, a 4-bit condition field is produced alongside the result.

Top module: `svs_exec`

## Requirements
- R1: After reset `result` is 0, `res_valid`, `cr_we` and `step_req` are 0, and both `pack` and `unpack` are 0.
- R2: Selectors 1 to 4 return the offset of shape 0 to 3 respectively. The offset is taken from bits [7k+6:7k] of `shape_off` for shape k and is zero-extended to 64 bits.
- R3: Selector 5 returns `src_step`, 6 returns `dst_step`, 7 returns `src_sub` and 8 returns `dst_sub`, each zero-extended to 64 bits.
- R4: Selectors 12 to 15 program the mode flags whatever `step_en` is. Selector 12 clears both flags, 13 sets `pack` and clears `unpack`, 14 sets `unpack` and clears `pack`, and 15 sets both.
- R5: For selectors 12 to 15 the result has bit 1 equal to the new `pack` and bit 0 equal to the new `unpack`. All other bits are zero.
- R6: Selector 0 with `step_en`=1 returns 0 and raises `step_req` for exactly the retire cycle. No other instruction raises `step_req`.
- R7: Selector 0 with `step_en`=0 and `rec`=0 is a no-operation. The result is 0, `cr_we` and `step_req` stay 0, and the flags are unchanged.
- R8: With `rec`=1, `cr_we` is high in the retire cycle and `cr_field` = {LT, GT, EQ, SO}, bit 3 down to bit 0. LT and GT come from the signed comparison of the result with zero. EQ is set when the result is zero. SO copies `so_in` as sampled at issue. With `rec`=0, `cr_we` is 0.
- R9: Selectors 9 to 11 and 16 to 127 are reserved. They return 0, leave the flags unchanged and raise no step request.
- R10: `res_valid` is high in the cycle after each cycle in which `issue` is high, and low otherwise. The outputs are registered, so each result appears one cycle after issue.
- R11: Selectors other than 12 to 15 never change `pack` or `unpack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | An instruction is presented this cycle |
| sel | input | 7 | Mode selector |
| step_en | input | 1 | Allow counter stepping |
| rec | input | 1 | Record flag: write the condition field |
| so_in | input | 1 | Summary overflow bit copied into the condition field |
| shape_off | input | 28 | Four 7-bit remap offsets, shape k in bits [7k+6:7k] |
| src_step | input | 7 | Current source element step |
| dst_step | input | 7 | Current destination element step |
| src_sub | input | 7 | Current source sub-step |
| dst_sub | input | 7 | Current destination sub-step |
| result | output | 64 | Instruction result |
| res_valid | output | 1 | Retire cycle of an instruction |
| cr_we | output | 1 | Condition field write enable |
| cr_field | output | 4 | Condition field {LT, GT, EQ, SO} |
| pack | output | 1 | Pack mode flag |
| unpack | output | 1 | Unpack mode flag |
| step_req | output | 1 | Request to the stepping iterator to advance both counters |

## Verification
The bench targets the boundaries of the selector decode: 0, 4/5, 8/9, 11/12, 15/16 and 127. A decoder that is off by one at any of these returns a neighbour's value, or programs the flags where it should return zero. It checks that selectors 13 and 14 put their flags in the right bit positions, since a swapped pair would invert pack and unpack. It checks that selector 0 with step-enable low raises no step request. It also checks that query selectors with step-enable high leave the flags untouched. Back-to-back issues make sure that a chained instruction keeps `res_valid` high and does not drop a result.

// File: rtl/svs_pkg.sv
package svs_pkg;

    typedef enum logic [2:0] {
        OP_STEP  = 3'd0,
        OP_SHAPE = 3'd1,
        OP_INDEX = 3'd2,
        OP_MODE  = 3'd3,
        OP_RSVD  = 3'd4
    } svs_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RETIRE = 1'b1
    } svs_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } svs_cr_t;

endpackage

// File: rtl/svs_decode.sv
module svs_decode
    import svs_pkg::*;
#(
    parameter int SEL_W  = 7,
    parameter int NSHAPE = 4
) (
    input  logic [SEL_W-1:0] sel,
    output svs_op_e          op,
    output logic [1:0]       sub_idx
);
    localparam int IDX_LO  = NSHAPE + 1;
    localparam int IDX_HI  = NSHAPE + 4;
    localparam int MODE_LO = 12;
    localparam int MODE_HI = 15;

    always_comb begin
        op      = OP_RSVD;
        sub_idx = 2'd0;
        if (int'(sel) == 0) begin
            op = OP_STEP;
        end else if (int'(sel) <= NSHAPE) begin
            op      = OP_SHAPE;
            sub_idx = 2'(int'(sel) - 1);
        end else if (int'(sel) >= IDX_LO && int'(sel) <= IDX_HI) begin
            op      = OP_INDEX;
            sub_idx = 2'(int'(sel) - IDX_LO);
        end else if (int'(sel) >= MODE_LO && int'(sel) <= MODE_HI) begin
            op = OP_MODE;
        end
    end
endmodule

// File: rtl/svs_query.sv
module svs_query
    import svs_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int IDX_W  = 7,
    parameter int NSHAPE = 4
) (
    input  svs_op_e                  op,
    input  logic [1:0]               sub_idx,
    input  logic [NSHAPE*IDX_W-1:0]  shape_off,
    input  logic [IDX_W-1:0]         src_step,
    input  logic [IDX_W-1:0]         dst_step,
    input  logic [IDX_W-1:0]         src_sub,
    input  logic [IDX_W-1:0]         dst_sub,
    input  logic                     new_pack,
    input  logic                     new_unpack,
    output logic [XLEN-1:0]          value
);
    logic [IDX_W-1:0] shape_arr [NSHAPE];
    logic [IDX_W-1:0] idx_val;

    for (genvar k = 0; k < NSHAPE; k++) begin : g_shape
        assign shape_arr[k] = shape_off[k*IDX_W +: IDX_W];
    end

    always_comb begin
        unique case (sub_idx)
            2'd0: idx_val = src_step;
            2'd1: idx_val = dst_step;
            2'd2: idx_val = src_sub;
            default: idx_val = dst_sub;
        endcase
    end

    always_comb begin
        value = '0;
        unique case (op)
            OP_SHAPE: value[IDX_W-1:0] = shape_arr[sub_idx];
            OP_INDEX: value[IDX_W-1:0] = idx_val;
            OP_MODE:  value[1:0]       = {new_pack, new_unpack};
            default:  value            = '0;
        endcase
    end
endmodule

// File: rtl/svs_crgen.sv
module svs_crgen
    import svs_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value,
    input  logic            so_in,
    output svs_cr_t         cr
);
    always_comb begin
        cr.lt = value[XLEN-1];
        cr.eq = (value == '0);
        cr.gt = !value[XLEN-1] && (value != '0);
        cr.so = so_in;
    end
endmodule

// File: rtl/svs_exec.sv
module svs_exec
    import svs_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int SEL_W  = 7,
    parameter int IDX_W  = 7,
    parameter int NSHAPE = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue,
    input  logic [SEL_W-1:0]        sel,
    input  logic                    step_en,
    input  logic                    rec,
    input  logic                    so_in,
    input  logic [NSHAPE*IDX_W-1:0] shape_off,
    input  logic [IDX_W-1:0]        src_step,
    input  logic [IDX_W-1:0]        dst_step,
    input  logic [IDX_W-1:0]        src_sub,
    input  logic [IDX_W-1:0]        dst_sub,
    output logic [XLEN-1:0]         result,
    output logic                    res_valid,
    output logic                    cr_we,
    output logic [3:0]              cr_field,
    output logic                    pack,
    output logic                    unpack,
    output logic                    step_req
);
    svs_state_e       state_q, state_d;
    svs_op_e          op;
    logic [1:0]       sub_idx;
    logic             new_pack, new_unpack;
    logic [XLEN-1:0]  value;
    svs_cr_t          cr_d;

    svs_decode #(.SEL_W(SEL_W), .NSHAPE(NSHAPE)) u_decode (
        .sel(sel), .op(op), .sub_idx(sub_idx)
    );

    always_comb begin
        new_pack   = pack;
        new_unpack = unpack;
        if (op == OP_MODE) begin
            new_pack   = sel[0];
            new_unpack = sel[1];
        end
    end

    svs_query #(.XLEN(XLEN), .IDX_W(IDX_W), .NSHAPE(NSHAPE)) u_query (
        .op(op), .sub_idx(sub_idx), .shape_off(shape_off),
        .src_step(src_step), .dst_step(dst_step),
        .src_sub(src_sub), .dst_sub(dst_sub),
        .new_pack(new_pack), .new_unpack(new_unpack), .value(value)
    );

    svs_crgen #(.XLEN(XLEN)) u_crgen (
        .value(value), .so_in(so_in), .cr(cr_d)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = issue ? ST_RETIRE : ST_IDLE;
            ST_RETIRE: state_d = issue ? ST_RETIRE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign res_valid = (state_q == ST_RETIRE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            cr_we    <= 1'b0;
            cr_field <= 4'd0;
            step_req <= 1'b0;
            pack     <= 1'b0;
            unpack   <= 1'b0;
        end else begin
            cr_we    <= 1'b0;
            step_req <= 1'b0;
            if (issue) begin
                result   <= value;
                cr_we    <= rec;
                cr_field <= cr_d;
                step_req <= (op == OP_STEP) && step_en;
                pack     <= new_pack;
                unpack   <= new_unpack;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !step_req && !cr_we && !pack && !unpack));

    assert_step_zero_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> (result == '0 && res_valid));

    assert_step_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !step_en) |=> !step_req);

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && sel[SEL_W-1:2] == 3) |=> $stable({pack, unpack}));

    assert_cr_one_compare_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr_field[3:1]) == 1 && res_valid));

    assert_cr_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && result == '0) |-> cr_field[1]);

    assert_valid_follows_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_valid);

    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !res_valid);

    assert_mode_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && sel[SEL_W-1:2] == 3) |=> (result[1:0] == {pack, unpack} && result[XLEN-1:2] == '0));
endmodule

// File: tb/svs_exec_tb.sv
module svs_exec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [6:0]  sel = '0;
    logic        step_en = 1'b0, rec = 1'b0, so_in = 1'b0;
    logic [27:0] shape_off = '0;
    logic [6:0]  src_step = '0, dst_step = '0, src_sub = '0, dst_sub = '0;
    logic [63:0] result;
    logic        res_valid, cr_we, pack, unpack, step_req;
    logic [3:0]  cr_field;

    int n_tests = 0;
    int n_fail  = 0;
    logic m_pack = 1'b0, m_unpack = 1'b0;

    always #2.5 clk = ~clk;

    svs_exec u_dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .sel(sel),
        .step_en(step_en), .rec(rec), .so_in(so_in), .shape_off(shape_off),
        .src_step(src_step), .dst_step(dst_step), .src_sub(src_sub), .dst_sub(dst_sub),
        .result(result), .res_valid(res_valid), .cr_we(cr_we), .cr_field(cr_field),
        .pack(pack), .unpack(unpack), .step_req(step_req)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_result(logic [6:0] s, logic np, logic nu);
        logic [63:0] r = '0;
        if (s >= 1 && s <= 4)        r[6:0] = shape_off[(int'(s)-1)*7 +: 7];
        else if (s == 5)             r[6:0] = src_step;
        else if (s == 6)             r[6:0] = dst_step;
        else if (s == 7)             r[6:0] = src_sub;
        else if (s == 8)             r[6:0] = dst_sub;
        else if (s >= 12 && s <= 15) r[1:0] = {np, nu};
        return r;
    endfunction

    task automatic run_op(logic [6:0] s, logic se, logic rc, logic so);
        logic [63:0] er;
        logic np, nu;
        string tag;
        sel = s; step_en = se; rec = rc; so_in = so;
        shape_off = {$urandom, $urandom} & 28'hFFFFFFF;
        src_step = 7'($urandom); dst_step = 7'($urandom);
        src_sub  = 7'($urandom); dst_sub  = 7'($urandom);
        issue = 1'b1;
        np = m_pack; nu = m_unpack;
        if (s >= 12 && s <= 15) begin np = s[0]; nu = s[1]; end
        er = exp_result(s, np, nu);
        @(negedge clk);
        issue = 1'b0;
        if (s >= 1 && s <= 4)        tag = "R2";
        else if (s >= 5 && s <= 8)   tag = "R3";
        else if (s >= 12 && s <= 15) tag = "R5";
        else if (s == 0)             tag = "R6";
        else                         tag = "R9";
        check(tag, result, er);
        check("R10 valid", 64'(res_valid), 64'd1);
        check((s >= 12 && s <= 15) ? "R4 flags" : "R11 flags", 64'({pack, unpack}), 64'({np, nu}));
        check("R6 step_req", 64'(step_req), 64'(s == 0 && se));
        check("R8 cr_we", 64'(cr_we), 64'(rc));
        if (rc) check("R8 cr_field", 64'(cr_field), 64'({1'b0, er != 0, er == 0, so}));
        m_pack = np; m_unpack = nu;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 result", result, 64'd0);
        check("R1 ctl", 64'({res_valid, cr_we, step_req, pack, unpack}), 64'd0);

        // R7 no-op
        run_op(7'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 idle", 64'(res_valid), 64'd0);

        // R4 flag encodings
        run_op(7'd13, 1'b0, 1'b1, 1'b1);
        run_op(7'd14, 1'b1, 1'b0, 1'b0);
        run_op(7'd15, 1'b0, 1'b1, 1'b0);
        run_op(7'd5,  1'b1, 1'b1, 1'b0);   // R11 with step_en high
        run_op(7'd12, 1'b0, 1'b1, 1'b0);
        run_op(7'd15, 1'b0, 1'b0, 1'b0);

        // decode boundaries
        run_op(7'd0,   1'b1, 1'b1, 1'b1);
        run_op(7'd1,   1'b0, 1'b1, 1'b0);
        run_op(7'd4,   1'b0, 1'b0, 1'b0);
        run_op(7'd5,   1'b0, 1'b0, 1'b0);
        run_op(7'd8,   1'b0, 1'b1, 1'b0);
        run_op(7'd9,   1'b1, 1'b1, 1'b1);
        run_op(7'd11,  1'b0, 1'b0, 1'b0);
        run_op(7'd16,  1'b1, 1'b0, 1'b0);
        run_op(7'd127, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        check("R6 pulse ends", 64'(step_req), 64'd0);

        for (int i = 0; i < 300; i++) begin
            logic [6:0] s;
            s = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 17);
            run_op(s, 1'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 3 == 0) begin
                @(negedge clk);
                check("R10 idle", 64'(res_valid), 64'd0);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule